// File: doc/BRIEF.md
# Byte-Counted FIFO with Fill-Level Checks

This block is a byte-counted FIFO that a serial controller places on its transmit side and on its receive side. Its storage is counted in bytes, but each push or pop moves one entry of 1, 2 or 4 bytes, as set by a width mode. Bytes are stored lowest lane first, so data written at one width can be read back at another with the byte order kept.

A host programs the block through a small write port with three words:
- a control word that holds the entry width and an entry threshold;
- an operation word that empties, starts or stops the FIFO;
- a check word that holds three 6-bit marks (stop, low, high).

The FIFO reports its fill level and its full and empty flags as one status word. It raises a threshold flag so that a host can refill a transmit FIFO or drain a receive FIFO early. It also compares its fill, counted in 32-bit units, against the three marks to pace a DMA or host agent. A parameter chooses the transmit or the receive sense of the threshold and stop comparisons.

Top module: `byte_fifo_lvl`

## Requirements
- R1: After reset the status word reads empty (bit 9 = 1), not full (bit 8 = 0), level 0. `pop_data`, `overflow` and `underflow` are 0, and the FIFO is stopped.
- R2: A host write to address 1 acts on the FIFO as follows. Bit 0 empties the FIFO and leaves it stopped. Bit 1 alone starts it. When both bits are set, emptying wins and the FIFO stays stopped. A value of 0 stops the FIFO and keeps its contents.
- R3: A push while full is ignored and leaves the contents unchanged. In the following cycle `overflow` is 1 for one cycle.
- R4: A pop while the FIFO is running and empty sets `pop_data` to zero. In the following cycle `underflow` is 1 for one cycle.
- R5: Control word (address 0) bits [1:0] select the entry size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. A push stores only the low entry-size bytes of `push_data`. A pop returns them zero-extended.
- R6: Storage is byte-addressed and little-endian. Bytes pushed at one width pop out in the same order at any other width. For example, the 32-bit word 0x44332211 pops as the bytes 0x11, 0x22, 0x33, 0x44.
- R7: The status level in bits [7:0] is the stored byte count divided by the entry size, truncated to 8 bits. Full means the free bytes are fewer than one entry. Empty means the stored bytes are fewer than one entry.
- R8: Control bits [9:2] hold an entry threshold. When `IS_TX` = 0, `thr_hit` is 1 when the level is at or above the threshold. When `IS_TX` = 1, it is 1 when the level is at or below the threshold.
- R9: The check word (address 2) holds stop in bits [5:0], low in bits [15:10] and high in bits [25:20]. Each mark is compared with the byte count divided by 4. `low_hit` is 1 when that count is at or below low. `high_hit` is 1 when it is at or above high. `stop_hit` is 1 when it is at or above stop if `IS_TX` = 1, and at or below stop if `IS_TX` = 0.
- R10: While the FIFO is stopped, pushes are ignored, and pops return zero without raising `underflow`.
- R11: A push and a pop in the same cycle on a FIFO that is neither full nor empty both take effect, and the level is unchanged.
- R12: `pop_data` changes in the cycle after a pop and holds its value until the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 control, 1 operation, 2 check marks |
| host_wdata | input | 32 | Host write data |
| push | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push, low bytes used |
| pop | input | 1 | Pop one entry |
| pop_data | output | 32 | Last popped entry, zero-extended |
| status | output | 10 | {empty, full, level[7:0]} |
| thr_hit | output | 1 | Level has reached the threshold |
| stop_hit | output | 1 | Stop mark reached |
| low_hit | output | 1 | At or below low mark |
| high_hit | output | 1 | At or above high mark |
| overflow | output | 1 | One-cycle pulse: push refused while full |
| underflow | output | 1 | One-cycle pulse: pop on empty running FIFO |

## Verification
The bench fills the FIFO to exactly 256 bytes with 32-bit entries, then switches to byte width. In byte width the level must wrap to 0 while full stays set; a level kept in entries of a fixed width, or a full flag taken from the level, would show the wrong status. A push after filling must leave the first word intact and raise overflow; a design that writes anyway would return a corrupted word. The bench writes a 32-bit word and reads it back byte by byte to catch reversed lane order. It also writes both operation bits at once, checks that the stop command keeps the contents, and compares the threshold and stop flags of a receive and a transmit instance at the level where each flips. Swapped comparison senses or an off-by-one mark show up there.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_WIDE = 2'd3
    } width_e;

    typedef struct packed {
        logic [7:0] thresh;
        width_e     width;
    } ctrl_t;

    typedef struct packed {
        logic [5:0] high;
        logic [5:0] low;
        logic [5:0] stop;
    } marks_t;

    typedef struct packed {
        logic       empty;
        logic       full;
        logic [7:0] level;
    } status_t;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_OP    = 2'd1;
    localparam logic [1:0] REG_MARKS = 2'd2;

    function automatic logic [2:0] entry_bytes(width_e w);
        case (w)
            W_BYTE:  return 3'd1;
            W_HALF:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] entry_shift(width_e w);
        case (w)
            W_BYTE:  return 2'd0;
            W_HALF:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/fifo_lvl_cfg.sv
module fifo_lvl_cfg
    import fifo_lvl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output ctrl_t       ctrl,
    output marks_t      marks,
    output logic        running,
    output logic        flush
);
    logic op_wr;

    assign op_wr = host_wr && (host_addr == REG_OP);
    // emptying wins over start in the same write
    assign flush = op_wr && host_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{thresh: 8'd0, width: W_BYTE};
            marks   <= '0;
            running <= 1'b0;
        end else begin
            if (host_wr && host_addr == REG_CTRL) begin
                ctrl.width  <= width_e'(host_wdata[1:0]);
                ctrl.thresh <= host_wdata[9:2];
            end
            if (host_wr && host_addr == REG_MARKS) begin
                marks.stop <= host_wdata[5:0];
                marks.low  <= host_wdata[15:10];
                marks.high <= host_wdata[25:20];
            end
            if (flush)
                running <= 1'b0;
            else if (op_wr)
                running <= host_wdata[1];
        end
    end
endmodule

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic              rd_zero,
    input  logic [2:0]        nbytes,
    input  logic [8*LANES-1:0] wr_data,
    output logic [8*LANES-1:0] rd_data,
    output logic [CW-1:0]     byte_cnt
);
    logic [7:0]          mem [DEPTH];
    logic [AW-1:0]       wptr, rptr;
    logic [8*LANES-1:0]  rd_word;
    logic [CW-1:0]       add_n, sub_n;

    always_comb begin
        for (int k = 0; k < LANES; k++)
            rd_word[8*k +: 8] = (k < int'(nbytes)) ? mem[rptr + AW'(k)] : 8'd0;
    end

    assign add_n = wr_ok ? CW'(nbytes) : '0;
    assign sub_n = rd_ok ? CW'(nbytes) : '0;

    always_ff @(posedge clk) begin
        if (wr_ok && !flush && !rst) begin
            for (int k = 0; k < LANES; k++)
                if (k < int'(nbytes))
                    mem[wptr + AW'(k)] <= wr_data[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr     <= '0;
            rptr     <= '0;
            byte_cnt <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(nbytes);
            if (rd_ok) rptr <= rptr + AW'(nbytes);
            byte_cnt <= byte_cnt + add_n - sub_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_ok && !flush)
            rd_data <= rd_word;
        else if (rd_zero || (rd_ok && flush))
            rd_data <= '0;
    end
endmodule

// File: rtl/fifo_lvl_eval.sv
module fifo_lvl_eval
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter bit IS_TX = 1'b0,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] byte_cnt,
    input  ctrl_t         ctrl,
    input  marks_t        marks,
    output status_t       status,
    output logic          thr_hit,
    output logic          stop_hit,
    output logic          low_hit,
    output logic          high_hit
);
    logic [2:0]    nb;
    logic [CW-1:0] entries;
    int            words;
    int            free_b;

    assign nb      = entry_bytes(ctrl.width);
    assign entries = byte_cnt >> entry_shift(ctrl.width);
    assign words   = int'(byte_cnt) / 4;
    assign free_b  = DEPTH - int'(byte_cnt);

    assign status.level = entries[7:0];
    assign status.full  = free_b < int'(nb);
    assign status.empty = int'(byte_cnt) < int'(nb);

    assign low_hit  = words <= int'(marks.low);
    assign high_hit = words >= int'(marks.high);

    generate
        if (IS_TX) begin : g_tx
            assign thr_hit  = int'(entries) <= int'(ctrl.thresh);
            assign stop_hit = words >= int'(marks.stop);
        end else begin : g_rx
            assign thr_hit  = int'(entries) >= int'(ctrl.thresh);
            assign stop_hit = words <= int'(marks.stop);
        end
    endgenerate
endmodule

// File: rtl/byte_fifo_lvl.sv
module byte_fifo_lvl
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter bit IS_TX = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] pop_data,
    output logic [9:0]  status,
    output logic        thr_hit,
    output logic        stop_hit,
    output logic        low_hit,
    output logic        high_hit,
    output logic        overflow,
    output logic        underflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    ctrl_t         ctrl;
    marks_t        marks;
    status_t       st;
    logic          running, flush;
    logic          wr_ok, rd_ok, rd_zero;
    logic [CW-1:0] byte_cnt;

    fifo_lvl_cfg u_cfg (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .ctrl(ctrl), .marks(marks), .running(running), .flush(flush)
    );

    assign wr_ok   = push && running && !st.full;
    assign rd_ok   = pop && running && !st.empty;
    assign rd_zero = pop && !rd_ok;

    fifo_byte_store #(.DEPTH(DEPTH), .LANES(4)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_zero(rd_zero),
        .nbytes(entry_bytes(ctrl.width)),
        .wr_data(push_data), .rd_data(pop_data), .byte_cnt(byte_cnt)
    );

    fifo_lvl_eval #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_eval (
        .byte_cnt(byte_cnt), .ctrl(ctrl), .marks(marks), .status(st),
        .thr_hit(thr_hit), .stop_hit(stop_hit),
        .low_hit(low_hit), .high_hit(high_hit)
    );

    assign status = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= push && running && st.full && !flush;
            underflow <= pop && running && st.empty && !flush;
        end
    end
endmodule

// File: rtl/fifo_lvl_checker.sv
module fifo_lvl_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic [1:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        push,
    input logic        pop,
    input logic [31:0] pop_data,
    input logic [9:0]  status,
    input logic        overflow,
    input logic        underflow
);
    p_empty_after_flush_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd1 && host_wdata[0]) |=> (status[9] && status[7:0] == 8'd0));

    p_ovf_from_full_push_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> ($past(push) && $past(status[8])));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (push && status[8] && !pop && !host_wr) |=> (status[8] && $stable(status)));

    p_udf_zero_r4: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (pop_data == 32'd0));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(status[8] && status[9]));

    p_level_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !status[8] && !status[9] && !host_wr) |=> $stable(status));
endmodule

bind byte_fifo_lvl fifo_lvl_checker u_chk (.*);

// File: tb/sim_byte_fifo_lvl.sv
module sim_byte_fifo_lvl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [1:0]  host_addr;
    logic [31:0] host_wdata;
    logic        push;
    logic [31:0] push_data;
    logic        pop;

    logic [31:0] pop_data, pop_data1;
    logic [9:0]  status, status1;
    logic        thr_hit, stop_hit, low_hit, high_hit, overflow, underflow;
    logic        thr_hit1, stop_hit1, low_hit1, high_hit1, overflow1, underflow1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_fifo_lvl #(.IS_TX(1'b0)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .status(status), .thr_hit(thr_hit),
        .stop_hit(stop_hit), .low_hit(low_hit), .high_hit(high_hit),
        .overflow(overflow), .underflow(underflow)
    );

    byte_fifo_lvl #(.IS_TX(1'b1)) u1 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data1), .status(status1), .thr_hit(thr_hit1),
        .stop_hit(stop_hit1), .low_hit(low_hit1), .high_hit(high_hit1),
        .overflow(overflow1), .underflow(underflow1)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic push1(logic [31:0] d);
        @(negedge clk);
        push = 1'b1; push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic restart();
        hw(2'd1, 32'h1);
        hw(2'd1, 32'h2);
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(status), 32'h200);
        chk("R1 pop_data", pop_data, 32'h0);
        chk("R1 ovf/udf", {30'd0, overflow, underflow}, 32'h0);
        push1(32'h55);
        chk("R1 stopped after reset", 32'(status), 32'h200);
    endtask

    task automatic t_stopped();
        push1(32'hAA);
        chk("R10 push while stopped", 32'(status), 32'h200);
        pop1();
        chk("R10 pop while stopped data", pop_data, 32'h0);
        chk("R10 pop while stopped no underflow", 32'(underflow), 32'h0);
    endtask

    task automatic t_bytes();
        restart();
        hw(2'd0, 32'h0);
        push1(32'hFFFFFF11);
        push1(32'h22);
        push1(32'h33);
        chk("R7 level 3 bytes", 32'(status), 32'h003);
        pop1();
        chk("R5 byte pop zero-extended", pop_data, 32'h11);
        @(negedge clk);
        chk("R12 pop_data held", pop_data, 32'h11);
        pop1();
        chk("R12 next pop", pop_data, 32'h22);
    endtask

    task automatic t_mixed();
        restart();
        hw(2'd0, 32'h2);
        push1(32'h44332211);
        chk("R7 one word", 32'(status), 32'h001);
        hw(2'd0, 32'h0);
        chk("R7 four bytes", 32'(status), 32'h004);
        pop1(); chk("R6 lane0", pop_data, 32'h11);
        pop1(); chk("R6 lane1", pop_data, 32'h22);
        hw(2'd0, 32'h1);
        pop1(); chk("R6 half from word", pop_data, 32'h4433);
        chk("R7 empty again", 32'(status), 32'h200);
        push1(32'h1234BEEF);
        hw(2'd0, 32'h0);
        chk("R5 half stores two bytes", 32'(status), 32'h002);
    endtask

    task automatic t_full();
        restart();
        hw(2'd0, 32'h2);
        for (int i = 0; i < 63; i++) push1(32'hA0000000 + 32'(i));
        chk("R7 63 words not full", 32'(status), 32'h03F);
        push1(32'hA000003F);
        chk("R7 full at 256 bytes", 32'(status), 32'h140);
        push1(32'hDEADBEEF);
        chk("R3 overflow pulse", 32'(overflow), 32'h1);
        chk("R3 level unchanged", 32'(status), 32'h140);
        @(negedge clk);
        chk("R3 overflow one cycle", 32'(overflow), 32'h0);
        hw(2'd0, 32'h0);
        chk("R7 byte level wraps, full kept", 32'(status), 32'h100);
        hw(2'd0, 32'h2);
        pop1();
        chk("R3 first word intact", pop_data, 32'hA0000000);
    endtask

    task automatic t_underflow();
        restart();
        hw(2'd0, 32'h2);
        push1(32'h5A5A5A5A);
        pop1();
        chk("R12 pop before underflow", pop_data, 32'h5A5A5A5A);
        pop1();
        chk("R4 empty pop data", pop_data, 32'h0);
        chk("R4 underflow pulse", 32'(underflow), 32'h1);
    endtask

    task automatic t_ops();
        restart();
        hw(2'd0, 32'h0);
        push1(32'h61);
        push1(32'h62);
        hw(2'd1, 32'h0);
        chk("R2 stop keeps contents", 32'(status), 32'h002);
        push1(32'h63);
        chk("R10 push ignored when stopped", 32'(status), 32'h002);
        hw(2'd1, 32'h2);
        pop1();
        chk("R2 restart keeps order", pop_data, 32'h61);
        hw(2'd1, 32'h3);
        chk("R2 both bits empties", 32'(status), 32'h200);
        push1(32'h64);
        chk("R2 both bits leaves stopped", 32'(status), 32'h200);
    endtask

    task automatic t_thresh();
        restart();
        hw(2'd0, (32'd3 << 2));
        push1(32'h1); push1(32'h2);
        chk("R8 rx below thr", 32'(thr_hit), 32'h0);
        chk("R8 tx below thr", 32'(thr_hit1), 32'h1);
        push1(32'h3);
        chk("R8 rx at thr", 32'(thr_hit), 32'h1);
        chk("R8 tx at thr", 32'(thr_hit1), 32'h1);
        push1(32'h4);
        chk("R8 rx above thr", 32'(thr_hit), 32'h1);
        chk("R8 tx above thr", 32'(thr_hit1), 32'h0);
    endtask

    task automatic t_marks();
        restart();
        hw(2'd0, 32'h2);
        hw(2'd2, 32'h1 | (32'd2 << 10) | (32'd3 << 20));
        chk("R9 empty rx low/high/stop", {29'd0, low_hit, high_hit, stop_hit}, 32'h5);
        chk("R9 empty tx stop", 32'(stop_hit1), 32'h0);
        push1(32'h11111111); push1(32'h22222222);
        chk("R9 two rx low/high/stop", {29'd0, low_hit, high_hit, stop_hit}, 32'h4);
        chk("R9 two tx stop", 32'(stop_hit1), 32'h1);
        push1(32'h33333333);
        chk("R9 three low/high", {30'd0, low_hit, high_hit}, 32'h1);
        @(negedge clk);
        push = 1'b1; pop = 1'b1; push_data = 32'h44444444;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        chk("R11 level kept", 32'(status), 32'h003);
        chk("R11 pop data", pop_data, 32'h11111111);
        pop1(); pop1(); pop1();
        chk("R11 pushed word last", pop_data, 32'h44444444);
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        push = 1'b0; push_data = '0; pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_bytes();
        t_mixed();
        t_full();
        t_underflow();
        t_ops();
        t_thresh();
        t_marks();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule